// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division, one result bit per clock, and holds its results in two architectural registers, HI and LO. A one-cycle `start` pulse with an operation code and two operands launches work. The unit then runs by itself, so the rest of a processor can keep issuing unrelated instructions while it runs. A multiply leaves the 64-bit product split across HI (upper half) and LO (lower half). A divide leaves the remainder in HI and the quotient in LO.

Results are read back through a move-style read port. Asserting `rd_hi` or `rd_lo` selects which register appears on `rd_data`. If such a read arrives while the unit is still working, `stall` rises and tells the requester to hold until the new values are in place. Sign handling converts both operands to magnitudes up front and corrects the signs of the result on the final step. Division by zero finishes in the usual time and leaves fixed values.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 2'b00 is a signed multiply. HI receives bits 63..32 and LO bits 31..0 of the two's-complement 64-bit product.
- R2: Operation code 2'b01 is an unsigned multiply. HI and LO receive the upper and lower halves of the 64-bit unsigned product.
- R3: Operation code 2'b11 is an unsigned divide. LO receives the quotient and HI the remainder.
- R4: Operation code 2'b10 is a signed divide. The quotient truncates toward zero, and the remainder carries the dividend's sign. The quotient of -2^31 by -1 is 32'h8000_0000 with remainder 0.
- R5: A divide by zero, signed or unsigned, leaves LO = 32'hFFFF_FFFF and HI = the dividend. It takes the same number of cycles as any other operation.
- R6: A `start` sampled while idle raises `busy` from the next cycle. `busy` stays high for exactly 32 cycles. HI and LO take their new values at the edge where `busy` falls and keep their old values until then.
- R7: `stall` is high exactly when `busy` is high and `rd_hi` or `rd_lo` is asserted.
- R8: A `start` sampled while `busy` is high is ignored. The running operation's result and its duration are unchanged.
- R9: `rd_data` shows HI when `rd_hi` is high, and LO otherwise. HI wins when both read inputs are high.
- R10: After reset, HI and LO are zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled while idle |
| op | input | 2 | Bit 1: divide; bit 0: unsigned |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| rd_hi | input | 1 | Read request for HI |
| rd_lo | input | 1 | Read request for LO |
| rd_data | output | 32 | Selected result register |
| busy | output | 1 | Operation in progress |
| stall | output | 1 | Read requested before the result is ready |

## Verification
The assertions assume that `rst_n` is applied once at the start and that all inputs change only between clock edges. They also assume that `start` is a single-cycle pulse, so a held `start` is just a new request on the cycle the unit goes idle. The stimulus drives every input one time unit after the rising edge. It releases `start` after one cycle, except in the deliberate case of a second pulse in the middle of an operation. It keeps read requests active during busy periods so that the stall path is exercised throughout.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         rd_hi,
  input  logic         rd_lo,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         stall
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy_q, is_div, neg_res, neg_rem, div0;
  logic [CW-1:0] cnt;
  logic [W:0]    up;
  logic [W-1:0]  lo_sh, dsr, hi_r, lo_r;

  wire sa = ~op[0] & opa[W-1];
  wire sb = ~op[0] & opb[W-1];
  wire [W-1:0] mag_a = sa ? -opa : opa;
  wire [W-1:0] mag_b = sb ? -opb : opb;
  wire launch = start & ~busy_q;

  // one multiply step
  wire [W:0]   msum = {1'b0, up[W-1:0]} + {1'b0, (lo_sh[0] ? dsr : '0)};
  wire [W:0]   m_up = {1'b0, msum[W:1]};
  wire [W-1:0] m_lo = {msum[0], lo_sh[W-1:1]};

  // one restoring divide step
  wire [W:0]   shl   = {up[W-1:0], lo_sh[W-1]};
  wire [W:0]   trial = shl - {1'b0, dsr};
  wire         fits  = ~trial[W];
  wire [W:0]   d_up  = fits ? trial : shl;
  wire [W-1:0] d_lo  = {lo_sh[W-2:0], fits};

  wire [W:0]   n_up = is_div ? d_up : m_up;
  wire [W-1:0] n_lo = is_div ? d_lo : m_lo;

  // final sign correction
  wire [2*W-1:0] prod  = {n_up[W-1:0], n_lo};
  wire [2*W-1:0] prodf = neg_res ? -prod : prod;
  wire [W-1:0]   quo   = div0 ? '1 : (neg_res ? -n_lo : n_lo);
  wire [W-1:0]   rem   = neg_rem ? -n_up[W-1:0] : n_up[W-1:0];
  wire           fin   = busy_q && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt     <= '0;
      up      <= '0;
      lo_sh   <= '0;
      dsr     <= '0;
      is_div  <= 1'b0;
      neg_res <= 1'b0;
      neg_rem <= 1'b0;
      div0    <= 1'b0;
      hi_r    <= '0;
      lo_r    <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      cnt     <= '0;
      up      <= '0;
      lo_sh   <= mag_a;
      dsr     <= mag_b;
      is_div  <= op[1];
      neg_res <= sa ^ sb;
      neg_rem <= sa;
      div0    <= op[1] && (opb == '0);
    end else if (busy_q) begin
      up    <= n_up;
      lo_sh <= n_lo;
      cnt   <= cnt + 1'b1;
      if (fin) begin
        busy_q <= 1'b0;
        hi_r   <= is_div ? rem : prodf[2*W-1:W];
        lo_r   <= is_div ? quo : prodf[W-1:0];
      end
    end
  end

  assign busy    = busy_q;
  assign stall   = busy_q & (rd_hi | rd_lo);
  assign rd_data = rd_hi ? hi_r : lo_r;

  // R6
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt) == LAST));
  // R6
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(hi_r) && $stable(lo_r)));
  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && cnt != LAST) |=> (busy_q && cnt == $past(cnt) + 1'b1));
  // R5
  div0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && $past(div0)) |-> (lo_r == '1));
endmodule

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;
  localparam int W = 32;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0;
  logic [1:0] op = 2'b00;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] rd_data;
  logic busy, stall;

  muldiv_hilo #(.W(W)) i_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .rd_data(rd_data), .busy(busy), .stall(stall));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string tag = "R10";
  bit done = 0;

  logic [W-1:0] m_hi = '0, m_lo = '0, p_hi, p_lo;
  int m_cnt = 0;

  function automatic logic [2*W-1:0] ref_res(logic [1:0] o, logic [W-1:0] a, logic [W-1:0] b);
    longint sp, sq, sr;
    logic [2*W-1:0] up;
    case (o)
      2'b00: begin sp = longint'($signed(a)) * longint'($signed(b)); return sp; end
      2'b01: begin up = {32'b0, a} * {32'b0, b}; return up; end
      2'b10: begin
        if (b == '0) return {a, 32'hFFFF_FFFF};
        sq = longint'($signed(a)) / longint'($signed(b));
        sr = longint'($signed(a)) % longint'($signed(b));
        return {sr[W-1:0], sq[W-1:0]};
      end
      default: begin
        if (b == '0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = '0; m_lo = '0; m_cnt = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_hi = p_hi; m_lo = p_lo; end
    end else if (start) begin
      {p_hi, p_lo} = ref_res(op, opa, opb);
      m_cnt = W;
    end
  end

  task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R6", "busy", W'(busy), W'(m_cnt > 0));
      check("R7", "stall", W'(stall), W'((m_cnt > 0) && (rd_hi || rd_lo)));
      if (m_cnt == 0) check(tag, "rd_data", rd_data, rd_hi ? m_hi : m_lo);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run(logic [1:0] o, logic [W-1:0] a, logic [W-1:0] b, bit second = 0);
    tick();
    start = 1'b1; op = o; opa = a; opb = b; rd_hi = 1'b1; rd_lo = 1'b0;
    tick();
    start = 1'b0; opa = $urandom; opb = $urandom; rd_hi = 1'b0; rd_lo = 1'b1;
    for (int i = 0; i < W + 1; i++) begin
      if (second && i == 9) begin start = 1'b1; op = ~o; end
      if (second && i == 10) start = 1'b0;
      tick();
    end
    rd_hi = 1'b1; rd_lo = 1'b0; tick();
    rd_hi = 1'b0; rd_lo = 1'b1; tick();
    rd_lo = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R10";
    repeat (2) tick();
    rd_hi = 1'b1; tick(); rd_hi = 1'b0; tick();
    rst_n = 1'b1; tick();
    tag = "R1";
    run(2'b00, -32'sd3, 32'sd7);
    run(2'b00, 32'h8000_0000, 32'h8000_0000);
    run(2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) run(2'b00, $urandom, $urandom);
    tag = "R2";
    run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) run(2'b01, $urandom, $urandom);
    tag = "R3";
    run(2'b11, 32'd100, 32'd7);
    run(2'b11, 32'hFFFF_FFFF, 32'd1);
    run(2'b11, 32'd5, 32'd9);
    for (int i = 0; i < 4; i++) run(2'b11, $urandom, $urandom >> (i * 7));
    tag = "R4";
    run(2'b10, -32'sd7, 32'sd2);
    run(2'b10, 32'sd7, -32'sd2);
    run(2'b10, -32'sd7, -32'sd2);
    run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) run(2'b10, $urandom, $urandom >> (i * 7));
    tag = "R5";
    run(2'b11, 32'h1234_5678, 32'd0);
    run(2'b10, -32'sd1000, 32'd0);
    run(2'b10, 32'd77, 32'd0);
    tag = "R8";
    run(2'b01, 32'h0001_0003, 32'h0002_0005, 1);
    run(2'b10, -32'sd99, 32'sd10, 1);
    tag = "R9";
    run(2'b01, 32'hDEAD_0001, 32'h0000_F00D);
    rd_hi = 1'b1; rd_lo = 1'b1; tick(); tick();
    rd_hi = 1'b0; rd_lo = 1'b0; tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule